// File: doc/BRIEF.md
# Chip-Select Kicked Watchdog

This block supervises a host processor by watching the SPI chip-select line, which doubles as the watchdog kick. While the watchdog is armed, a counter advances on every pulse of a prescaled tick input. A recognised high-to-low transition on the chip-select line restarts the count. If the line holds one level, high or low, for a full period without a recognised kick, the block raises a one-clock timeout pulse toward the reset sequencer. The sequencer then stretches that pulse into a system reset of about 200 ms.

A two-bit select field from the status register picks the period. Code `00` gives the long period (about 1.4 s), `01` the middle period (about 600 ms) and `10` the short period (about 200 ms). Code `11` turns the watchdog off, and it is the factory default. The three periods are parameters counted in ticks. A chip-select low pulse must last a minimum time (400 ns in the target system) to count as a kick. That minimum is a parameter counted in system clocks. The line passes through a synchronizer before it is examined. Writing a different select code clears the count, so the new period runs from that point. While system reset is active the count is held at zero.

Top module: `csn_watchdog`

## Requirements
- R1: While `rst_n` is low, `timeout` stays low and the count is held at zero. After release, the count starts from zero, so the first timeout comes a full period of ticks later, even if counting had been under way before the reset.
- R2: With `wd_sel` = 2'b00, `timeout` pulses on the `P_SLOW`-th tick after the last recognised kick, and on no earlier tick.
- R3: With `wd_sel` = 2'b01, `timeout` pulses on the `P_MID`-th tick after the last recognised kick, and on no earlier tick.
- R4: With `wd_sel` = 2'b10, `timeout` pulses on the `P_FAST`-th tick after the last recognised kick, and on no earlier tick.
- R5: With `wd_sel` = 2'b11, `timeout` never asserts, however many ticks arrive.
- R6: A timeout occurs whether the chip-select line is held continuously high or continuously low after the last kick.
- R7: Only a falling edge of the chip-select line can restart the count. A rising edge leaves the count running.
- R8: A low pulse that the synchronized line shows for fewer than `KICK_MIN_LOW` clocks is ignored. A low pulse of at least `KICK_MIN_LOW` clocks restarts the count once, at the clock where its low run reaches that length.
- R9: A change of `wd_sel` clears the count, and the newly selected period is measured from the change.
- R10: `timeout` is high for exactly one clock, one clock after the tick that completes the period. The count then restarts at zero, so the next timeout follows after another full period of ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset; holds the count at zero |
| tick | input | 1 | Prescaled timebase; one-clock pulse per tick |
| wd_sel | input | 2 | Period select: 00 long, 01 middle, 10 short, 11 off |
| cs_kick_n | input | 1 | Chip-select line used as kick; asynchronous, idles high |
| timeout | output | 1 | One-clock pulse when a period passes without a kick |

## Verification
Some properties are checked by assertions on every clock:
- the count stays below the limit of the registered select code;
- a timeout pulse is always followed by a cleared count;
- a select change clears the count on the next clock;
- a recognised kick is never followed directly by a timeout;
- one low run yields at most one kick;
- the off code produces no timeout.

Other behaviours can only be shown by the bench's scenarios:
- the exact tick on which each period expires;
- that a rising edge or a short glitch leaves the count running;
- that a line held low times out just as a line held high does;
- that the count starts from zero after reset or after a code change.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_SLOW = 2'b00,
        WD_MID  = 2'b01,
        WD_FAST = 2'b10,
        WD_OFF  = 2'b11
    } wd_sel_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/kick_filter.sv
module kick_filter #(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned KICK_MIN_LOW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic kick_evt
);
    localparam int unsigned LW = $clog2(KICK_MIN_LOW + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [LW-1:0]          low_run;
    } kf_state_t;

    kf_state_t q, d;
    logic      line_s;

    assign line_s   = q.sync[SYNC_STAGES-1];
    assign kick_evt = !line_s && (q.low_run == LW'(KICK_MIN_LOW - 1));

    always_comb begin
        d      = q;
        d.sync = SYNC_STAGES'({q.sync, line_n});
        if (line_s) begin
            d.low_run = '0;
        end else if (q.low_run != LW'(KICK_MIN_LOW)) begin
            d.low_run = q.low_run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync    <= '1;
            q.low_run <= '0;
        end else begin
            q <= d;
        end
    end

    // R8: one low run yields at most one recognised kick
    a_r8_single_kick: assert property (@(posedge clk) disable iff (!rst_n)
        kick_evt |=> !kick_evt);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned P_SLOW = 1400,
    parameter int unsigned P_MID  = 600,
    parameter int unsigned P_FAST = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] sel,
    input  logic       kick_evt,
    output logic       timeout
);
    localparam int unsigned PMAX = max3(P_SLOW, P_MID, P_FAST);
    localparam int unsigned CW   = $clog2(PMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        wd_sel_e       sel;
        logic          to;
    } core_state_t;

    core_state_t   q, d;
    wd_sel_e       sel_in;
    logic [CW-1:0] lim;

    function automatic logic [CW-1:0] lim_of(input wd_sel_e s);
        case (s)
            WD_SLOW: return CW'(P_SLOW);
            WD_MID:  return CW'(P_MID);
            WD_FAST: return CW'(P_FAST);
            default: return '0;
        endcase
    endfunction

    assign sel_in  = wd_sel_e'(sel);
    assign lim     = lim_of(sel_in);
    assign timeout = q.to;

    always_comb begin
        d     = q;
        d.to  = 1'b0;
        d.sel = sel_in;
        if (sel_in != q.sel || sel_in == WD_OFF || kick_evt) begin
            d.cnt = '0;
        end else if (tick) begin
            if (q.cnt == lim - 1'b1) begin
                d.cnt = '0;
                d.to  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.sel <= WD_OFF;
            q.to  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R2 R3 R4: count never reaches the limit of the registered code
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel != WD_OFF) |-> (q.cnt < lim_of(q.sel)));
    // R10: a timeout leaves the count restarted
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        q.to |-> (q.cnt == '0));
    // R9: select change clears the count
    a_r9_sel_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in != q.sel) |=> (q.cnt == '0));
    // R5: off code yields no timeout
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel == WD_OFF) |-> !q.to);

endmodule

// File: rtl/csn_watchdog.sv
module csn_watchdog #(
    parameter int unsigned P_SLOW       = 1400,
    parameter int unsigned P_MID        = 600,
    parameter int unsigned P_FAST       = 200,
    parameter int unsigned KICK_MIN_LOW = 20,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] wd_sel,
    input  logic       cs_kick_n,
    output logic       timeout
);
    logic kick_evt;

    kick_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .KICK_MIN_LOW(KICK_MIN_LOW)
    ) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_n  (cs_kick_n),
        .kick_evt(kick_evt)
    );

    wdt_core #(
        .P_SLOW(P_SLOW),
        .P_MID (P_MID),
        .P_FAST(P_FAST)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sel     (wd_sel),
        .kick_evt(kick_evt),
        .timeout (timeout)
    );

    // R7 R8: a recognised kick is never followed directly by a timeout
    a_r8_kick_restart: assert property (@(posedge clk) disable iff (!rst_n)
        kick_evt |=> !timeout);
    // R1: no timeout in the first clock after reset release
    a_r1_quiet_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !timeout);

endmodule

// File: tb/sim_csn_watchdog.sv
module sim_csn_watchdog;
    localparam int unsigned PS = 12;
    localparam int unsigned PM = 7;
    localparam int unsigned PF = 3;
    localparam int unsigned ML = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] wd_sel = 2'b00;
    logic       cs_kick_n = 1'b1;
    logic       timeout;
    logic       got;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    csn_watchdog #(
        .P_SLOW(PS), .P_MID(PM), .P_FAST(PF), .KICK_MIN_LOW(ML), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wd_sel(wd_sel),
        .cs_kick_n(cs_kick_n), .timeout(timeout)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic t);
        tick = t;
        @(negedge clk);
        got  = timeout;
        tick = 1'b0;
    endtask

    // apply n ticks; expect a pulse only on tick number 'at' (0 = never)
    task automatic run_ticks(input string req, input int n, input int at);
        for (int i = 1; i <= n; i++) begin
            step(1'b1);
            chk(req, int'(got), (i == at) ? 1 : 0);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic kick_low(input int len, input bit stay_low);
        cs_kick_n = 1'b0;
        idle(len);
        if (!stay_low) cs_kick_n = 1'b1;
        idle(ML + 3);
    endtask

    task automatic period_for(input logic [1:0] code, input int lim, input string req);
        wd_sel = code;
        idle(2);
        kick_low(ML + 2, 1'b0);
        run_ticks(req, lim, lim);
        run_ticks("R10", lim, lim);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset holds timeout low even with ticks
        for (int i = 0; i < 20; i++) begin
            step(1'b1);
            chk("R1", int'(got), 0);
        end
        wd_sel = 2'b10;
        rst_n  = 1'b1;
        idle(1);
        run_ticks("R1", PF, PF);

        // R2 R3 R4 with line held high, plus R10 re-arm
        period_for(2'b00, PS, "R2");
        period_for(2'b01, PM, "R3");
        period_for(2'b10, PF, "R4");

        // R6: line held low after the kick still times out
        wd_sel = 2'b01;
        idle(2);
        kick_low(ML + 2, 1'b1);
        run_ticks("R6", PM, PM);

        // R7: rising edge mid-count does not restart
        run_ticks("R7", 3, 0);
        cs_kick_n = 1'b1;
        idle(4);
        run_ticks("R7", PM - 3, PM - 3);

        // R8: short glitch ignored
        kick_low(ML + 2, 1'b0);
        run_ticks("R8", 2, 0);
        kick_low(ML - 1, 1'b0);
        run_ticks("R8", PM - 2, PM - 2);
        // R8: exactly the minimum width restarts
        run_ticks("R8", 2, 0);
        kick_low(ML, 1'b0);
        run_ticks("R8", PM, PM);

        // R9: select change clears the count
        wd_sel = 2'b00;
        idle(2);
        kick_low(ML + 2, 1'b0);
        run_ticks("R9", 5, 0);
        wd_sel = 2'b10;
        idle(1);
        run_ticks("R9", PF, PF);
        wd_sel = 2'b00;
        idle(1);
        run_ticks("R9", PS - 2, 0);
        wd_sel = 2'b01;
        idle(1);
        run_ticks("R9", PM, PM);

        // R5: off code never times out, line idle or held low
        wd_sel = 2'b11;
        idle(1);
        run_ticks("R5", 3 * PS, 0);
        cs_kick_n = 1'b0;
        run_ticks("R5", 2 * PS, 0);
        cs_kick_n = 1'b1;
        wd_sel = 2'b10;
        idle(3);
        run_ticks("R5", PF, PF);

        // R1: reset mid-count restarts from zero
        wd_sel = 2'b00;
        idle(2);
        kick_low(ML + 2, 1'b0);
        run_ticks("R1", 8, 0);
        rst_n = 1'b0;
        step(1'b1);
        chk("R1", int'(got), 0);
        step(1'b1);
        chk("R1", int'(got), 0);
        rst_n = 1'b1;
        idle(1);
        run_ticks("R1", PS, PS);

        // R10: pulse lasts one clock only
        wd_sel = 2'b10;
        idle(2);
        run_ticks("R10", PF, PF);
        step(1'b0);
        chk("R10", int'(got), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule